// File: doc/BRIEF.md
# Keyed Configuration Lock Register

This block is a 32-bit register that freezes the configuration of a 16-pin I/O port. Each low-order bit marks one pin whose configuration should no longer change. The combined lock mask goes to the neighbouring configuration registers, which refuse writes to any pin whose mask bit is set. The lock bits take effect only after a guard flag, the key, becomes active. Software cannot set the key by writing it. It becomes active only when the host follows a fixed access pattern: three writes, then a read.

The key-arming pattern is: a write with the key bit at 1, a write with the key bit at 0, a write with the key bit at 1, and then a read of this register. All three writes carry the same pin-lock value. Any other access to the register during the pattern cancels it. Once the key is active it cannot be cleared by software. Only a reset clears it. The host side is a plain synchronous port: select, write strobe, read strobe, write data, and registered read data.

Top module: `cfglock_top`

## Requirements
- R1: After reset the key is inactive, all pin-lock bits are 0, read data is 0 and the lock mask is 0.
- R2: A selected read (sel=1, rd_en=1, wr_en=0) returns, on the cycle after the strobe, a word with the pin-lock bits at [15:0], the key at bit 16 and zeros in bits [31:17]. The value returned is the state before that cycle's edge.
- R3: While the key is inactive, every selected write (sel=1, wr_en=1) stores wdata[15:0] into the pin-lock bits. Writing wdata[16] alone never sets the key. The lock mask stays 0.
- R4: The pattern write(bit16=1, V), write(bit16=0, V), write(bit16=1, V), then a selected read, activates the key on that read. The read itself returns key=0, the next read returns key=1, and from then on the lock mask equals V.
- R5: If a write in the pattern carries pin-lock bits different from the first write, the pattern is cancelled and the key stays inactive.
- R6: If a write in the pattern has the wrong bit-16 value, the pattern is cancelled and the key stays inactive.
- R7: A selected read before the third write of the pattern cancels the pattern.
- R8: Cycles with sel=0 neither advance nor cancel the pattern, and they do not change the register.
- R9: While the key is active, writes change neither the pin-lock bits nor the key. The key stays 1 and the lock mask holds its value.
- R10: Reset clears an active key and the pin-lock bits. A new pattern can then lock the register again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Register select for this access |
| wr_en | input | 1 | Write strobe (has priority over rd_en) |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data; bit 16 is the key, [15:0] the pin locks |
| rdata | output | 32 | Registered read data |
| lock_mask | output | 16 | Per-pin lock mask, 0 while the key is inactive |

## Verification
The main function is tried with several access patterns:
- A correct pattern, with unselected reads and writes interleaved to show that they are transparent.
- A pattern whose third write changes the pin bits.
- A pattern of three writes with bit 16 set, which has the wrong key order.
- A pattern cut short by an early read.

Each failed pattern must leave the key at 0 while the pin bits still follow the writes. This separates "pattern cancelled" from "writes blocked". After locking, writes of all-ones and all-zeros test the freeze. A reset followed by a second locking with a different value shows that the key is not stuck.

// File: rtl/cfglock_pkg.sv
package cfglock_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ONE   = 2'd1,
        SQ_ZERO  = 2'd2,
        SQ_ARMED = 2'd3
    } seq_st_e;

endpackage

// File: rtl/cfglock_seq.sv
module cfglock_seq
    import cfglock_pkg::*;
#(
    parameter int PINS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_acc,
    input  logic            rd_acc,
    input  logic            wkey,
    input  logic [PINS-1:0] wbits,
    input  logic            key_active,
    output logic            set_key
);

    typedef struct packed {
        seq_st_e         st;
        logic [PINS-1:0] cap;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        set_key = 1'b0;
        if (key_active) begin
            s_d.st = SQ_IDLE;
        end else begin
            unique case (s_q.st)
                SQ_IDLE: begin
                    if (wr_acc && wkey) begin
                        s_d.st  = SQ_ONE;
                        s_d.cap = wbits;
                    end
                end
                SQ_ONE: begin
                    if (wr_acc) begin
                        s_d.st = (!wkey && wbits == s_q.cap) ? SQ_ZERO : SQ_IDLE;
                    end else if (rd_acc) begin
                        s_d.st = SQ_IDLE;
                    end
                end
                SQ_ZERO: begin
                    if (wr_acc) begin
                        s_d.st = (wkey && wbits == s_q.cap) ? SQ_ARMED : SQ_IDLE;
                    end else if (rd_acc) begin
                        s_d.st = SQ_IDLE;
                    end
                end
                SQ_ARMED: begin
                    if (wr_acc) begin
                        s_d.st = SQ_IDLE;
                    end else if (rd_acc) begin
                        s_d.st  = SQ_IDLE;
                        set_key = 1'b1;
                    end
                end
                default: s_d.st = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st  <= SQ_IDLE;
            s_q.cap <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R9: once locked the pattern machine rests in idle
    a_r9_idle_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
        key_active |=> s_q.st == SQ_IDLE);

    // R8: no selected access, no state movement (while unlocked)
    a_r8_hold_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_acc && !rd_acc && !key_active) |=> $stable(s_q.st));

    // R7: a read outside the armed state never arms the key
    a_r7_read_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && s_q.st != SQ_ARMED) |-> !set_key);

endmodule

// File: rtl/cfglock_store.sv
module cfglock_store #(
    parameter int PINS = 16,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_acc,
    input  logic            rd_acc,
    input  logic [PINS-1:0] wbits,
    input  logic            set_key,
    output logic            key_q,
    output logic [PINS-1:0] bits_q,
    output logic [DW-1:0]   rdata_q
);

    localparam int KEY_POS = PINS;
    localparam int RSV_W   = DW - PINS - 1;

    logic            key_d;
    logic [PINS-1:0] bits_d;
    logic [DW-1:0]   rdata_d;
    logic [DW-1:0]   word;

    always_comb begin
        word          = '0;
        word[PINS-1:0] = bits_q;
        word[KEY_POS] = key_q;

        key_d   = key_q | set_key;
        bits_d  = (wr_acc && !key_q) ? wbits : bits_q;
        rdata_d = rd_acc ? word : rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q   <= 1'b0;
            bits_q  <= '0;
            rdata_q <= '0;
        end else begin
            key_q   <= key_d;
            bits_q  <= bits_d;
            rdata_q <= rdata_d;
        end
    end

    // R9: key is sticky
    a_r9_key_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        key_q |=> key_q);

    // R4: key rises only right after a selected read
    a_r4_key_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_q) |-> $past(rd_acc));

    // R9: pin bits frozen while locked
    a_r9_bits_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        key_q |=> $stable(bits_q));

    // R2: reserved bits always read zero
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_q[DW-1:KEY_POS+1] == '0);

    initial begin
        a_r2_width_ok: assert (RSV_W >= 1);
    end

endmodule

// File: rtl/cfglock_top.sv
module cfglock_top #(
    parameter int PINS = 16,
    parameter int DW   = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    output logic [15:0]   lock_mask
);

    localparam int KEY_POS = PINS;

    logic            wr_acc, rd_acc, set_key, key_q;
    logic [PINS-1:0] bits_q;
    logic [DW-1:0]   rdata_q;

    assign wr_acc = sel && wr_en;
    assign rd_acc = sel && rd_en && !wr_en;

    cfglock_seq #(.PINS(PINS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_acc     (wr_acc),
        .rd_acc     (rd_acc),
        .wkey       (wdata[KEY_POS]),
        .wbits      (wdata[PINS-1:0]),
        .key_active (key_q),
        .set_key    (set_key)
    );

    cfglock_store #(.PINS(PINS), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_acc  (wr_acc),
        .rd_acc  (rd_acc),
        .wbits   (wdata[PINS-1:0]),
        .set_key (set_key),
        .key_q   (key_q),
        .bits_q  (bits_q),
        .rdata_q (rdata_q)
    );

    assign rdata     = rdata_q;
    assign lock_mask = key_q ? bits_q : '0;

    // R3: mask stays dark until the read-back shows the key
    a_r3_mask_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[KEY_POS] == 1'b0 && $past(rd_acc) && !key_q) |-> lock_mask == '0);

    // R9: mask holds once locked
    a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (key_q && $past(key_q)) |-> $stable(lock_mask));

endmodule

// File: tb/tb_cfglock_top.sv
module tb_cfglock_top;

    localparam int CLK_PERIOD = 10;
    localparam int KEY = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] lock_mask;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          rd_fired = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfglock_top dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .lock_mask(lock_mask)
    );

    // monitor: note read strobes at the edge, compare after it
    always @(posedge clk) begin
        cycles   <= cycles + 1;
        rd_fired <= sel && rd_en && !wr_en && rst_n;
    end

    always @(negedge clk) begin
        if (rd_fired) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (rdata !== e) begin
                n_fail++;
                $display("FAIL %s rdata actual=%h expected=%h", t, rdata, e);
            end
        end
    end

    always @(posedge clk) begin
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic wr(input logic [31:0] d, input logic s = 1'b1);
        @(negedge clk);
        sel = s; wr_en = 1'b1; rd_en = 1'b0; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0;
    endtask

    task automatic rd(input logic [31:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(t);
        sel = 1'b1; rd_en = 1'b1; wr_en = 1'b0;
        @(negedge clk);
        sel = 1'b0; rd_en = 1'b0;
    endtask

    task automatic rd_unsel();
        @(negedge clk);
        sel = 1'b0; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_mask(input logic [15:0] e, input string t);
        @(negedge clk);
        n_tests++;
        if (lock_mask !== e) begin
            n_fail++;
            $display("FAIL %s lock_mask actual=%h expected=%h", t, lock_mask, e);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk_mask(16'h0, "R1");
        rd(32'h0, "R1");

        // R7: first write then read aborts; R3 bits follow write, key not set directly
        wr(KEY | 32'h00A5);
        rd(32'h0000_00A5, "R7/R3");
        rd(32'h0000_00A5, "R3");
        chk_mask(16'h0, "R3");

        // R5: changed bits on third write
        wr(KEY | 32'h1234);
        wr(32'h1234);
        wr(KEY | 32'h1235);
        rd(32'h0000_1235, "R5");
        rd(32'h0000_1235, "R5");
        chk_mask(16'h0, "R5");

        // R6: wrong bit-16 order 1,1,1
        wr(KEY | 32'h0F0F);
        wr(KEY | 32'h0F0F);
        wr(KEY | 32'h0F0F);
        rd(32'h0000_0F0F, "R6");
        rd(32'h0000_0F0F, "R6");

        // R7: read between second and third write
        wr(KEY | 32'h3333);
        wr(32'h3333);
        rd(32'h0000_3333, "R7");
        wr(KEY | 32'h3333);
        rd(32'h0000_3333, "R7");
        rd(32'h0000_3333, "R7");
        chk_mask(16'h0, "R7");

        // R4 + R8: good pattern with unselected traffic in between
        wr(KEY | 32'hC3A5);
        wr(32'hFFFF_FFFF, 1'b0);
        wr(32'hC3A5);
        rd_unsel();
        wr(KEY | 32'hC3A5);
        wr(32'h0000_0000, 1'b0);
        rd(32'h0000_C3A5, "R4/R8");
        rd(32'h0001_C3A5, "R4/R8");
        chk_mask(16'hC3A5, "R4");

        // R9: writes ignored after lock
        wr(32'h0000_FFFF);
        rd(32'h0001_C3A5, "R9");
        wr(32'h0000_0000);
        wr(32'h0001_0000);
        rd(32'h0001_C3A5, "R9");
        chk_mask(16'hC3A5, "R9");

        // R10: reset recovers, relock with new value
        do_reset();
        rd(32'h0, "R10");
        chk_mask(16'h0, "R10");
        wr(32'h0000_5A5A);
        rd(32'h0000_5A5A, "R10");
        wr(KEY | 32'h8001);
        wr(32'h8001);
        wr(KEY | 32'h8001);
        rd(32'h0000_8001, "R10");
        rd(32'h0001_8001, "R10");
        chk_mask(16'h8001, "R10");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_tests++; n_fail++;
            $display("FAIL R2 pending reads actual=%0d expected=0", exp_q.size());
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule